// File: doc/BRIEF.md
# Debug-Aware Program Status Register Access Unit

This unit holds a processor's current program status word and one saved copy of it. It serves the move-to and move-from status register operations. Each access carries the core's debug-state flag, a four-lane field-select mask and the write data. The application flags (negative, zero, carry, overflow, saturation and the four greater-or-equal bits) behave the same in every state. The execution-state bits are treated differently. Outside debug state they read as zero, except the endianness bit, and writes to them are dropped. In debug state they are fully readable and writable.

A debug-state write that changes any execution-state bit must be followed by an instruction-barrier pulse. The unit tracks that outstanding barrier. It flags a read of the current word that returns an unknown value while the barrier is outstanding. It also flags two unpredictable events: leaving debug state before the barrier, and a debug-state write that does not select all four lanes. The flags are combinational and appear in the same cycle as the offending request.

Top module: `psr_access_unit`

## Requirements
- R1: The flag bits 31:27 and 19:16 of the current word are written and read back unchanged whether the debug flag is high or low.
- R2: With the debug flag low, a read of the current word (rd_saved_i=0) returns 0 in execution-state bits 26:24, 15:10 and 5, and returns the stored value in the endianness bit 9.
- R3: With the debug flag low, a write to the current word leaves bits 26:24, 15:10 and 5 unchanged, while bit 9 is written like any other bit.
- R4: With the debug flag high, a read of the current word returns every stored bit, including all execution-state bits.
- R5: With the debug flag high, a write to the current word updates the execution-state bits of the selected lanes on the next clock edge.
- R6: Reads and writes of the saved word (rd_saved_i=1 / wr_saved_i=1) apply no state-dependent masking.
- R7: Field-mask bit k enables the write of bits 8k+7:8k. Lanes whose mask bit is 0 keep their value.
- R8: A debug-state write to the current word whose field mask is not 4'b1111 raises unpred_o in the same cycle.
- R9: sync_pend_o goes high after a debug-state write that changes any bit of 26:24, 15:9 or 5. It is cleared after a cycle with barrier_i high. A new setting write in that same cycle wins. Reset clears it.
- R10: A read of the current word (rd_en_i=1, rd_saved_i=0) while sync_pend_o is high raises unknown_o in the same cycle.
- R11: When the debug flag was high in the previous cycle, is low now, and sync_pend_o is high, unpred_o is raised in the same cycle.
- R12: After reset the current word is 32'h000001D3, the saved word is 0, and sync_pend_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dbg_i | input | 1 | Core is in debug state |
| wr_en_i | input | 1 | Write request |
| wr_saved_i | input | 1 | Write targets the saved word (else the current word) |
| field_mask_i | input | 4 | Byte-lane write enables |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read request (qualifies unknown_o) |
| rd_saved_i | input | 1 | Read the saved word (else the current word) |
| barrier_i | input | 1 | Instruction-barrier pulse |
| rd_data_o | output | 32 | Read data, combinational |
| sync_pend_o | output | 1 | Barrier outstanding after an execution-state write |
| unknown_o | output | 1 | The current read returns an unknown value |
| unpred_o | output | 1 | An unpredictable event occurs in this cycle |

## Verification
A corrupted stored word becomes visible on rd_data_o in the first cycle after the bad edge. It shows in a debug-state read for any bit, and in a non-debug read for flag bits or the endianness bit. A non-debug read cannot show a stray execution-state bit, so the sweep keeps returning to debug state to expose those bits. A wrong barrier-tracking state shows at sync_pend_o one cycle after the setting write or the barrier. It also shows on unknown_o and unpred_o when a read or a debug exit coincides with it.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int unsigned PSR_W = 32;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned LANES = PSR_W / LANE_W;

  // Execution-state bits: IT[1:0]=26:25, J=24, IT[7:2]=15:10, E=9, T=5
  localparam logic [PSR_W-1:0] EXEC_ALL  = 32'h0700_FE20;
  localparam logic [PSR_W-1:0] ENDIAN_B  = 32'h0000_0200;
  localparam logic [PSR_W-1:0] EXEC_NO_E = EXEC_ALL & ~ENDIAN_B;
  localparam logic [PSR_W-1:0] FLAG_BITS = 32'hF80F_0000;

  function automatic logic [PSR_W-1:0] merge_bits(input logic [PSR_W-1:0] old_v,
                                                  input logic [PSR_W-1:0] new_v,
                                                  input logic [PSR_W-1:0] en_v);
    return (old_v & ~en_v) | (new_v & en_v);
  endfunction

  function automatic logic [PSR_W-1:0] cur_view(input logic [PSR_W-1:0] v, input logic dbg);
    return dbg ? v : (v & ~EXEC_NO_E);
  endfunction
endpackage

// File: rtl/psr_write_path.sv
module psr_write_path
  import psr_pkg::*;
#(
  parameter bit PROTECT = 1'b1
) (
  input  logic [PSR_W-1:0] old_i,
  input  logic [PSR_W-1:0] data_i,
  input  logic [LANES-1:0] lanes_i,
  input  logic             en_i,
  input  logic             dbg_i,
  output logic [PSR_W-1:0] next_o,
  output logic             exec_chg_o
);
  logic             guard;
  logic [PSR_W-1:0] keep_mask;
  logic [PSR_W-1:0] lane_bits;
  logic [PSR_W-1:0] wr_bits;

  assign guard     = PROTECT && !dbg_i;
  assign keep_mask = guard ? EXEC_NO_E : '0;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_bits[g*LANE_W +: LANE_W] = {LANE_W{lanes_i[g] & en_i}};
    end
  endgenerate

  assign wr_bits    = lane_bits & ~keep_mask;
  assign next_o     = merge_bits(old_i, data_i, wr_bits);
  assign exec_chg_o = |((next_o ^ old_i) & EXEC_ALL);
endmodule

// File: rtl/psr_sync_tracker.sv
module psr_sync_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic dbg_i,
  input  logic set_i,
  input  logic barrier_i,
  input  logic partial_i,
  input  logic rd_cur_i,
  output logic pend_o,
  output logic unknown_o,
  output logic unpred_o
);
  logic dbg_q;
  logic pend_q;
  logic exit_ev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dbg_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      dbg_q <= dbg_i;
      if (set_i)          pend_q <= 1'b1;
      else if (barrier_i) pend_q <= 1'b0;
    end
  end

  assign exit_ev   = dbg_q & ~dbg_i;
  assign pend_o    = pend_q;
  assign unknown_o = rd_cur_i & pend_q;
  assign unpred_o  = partial_i | (exit_ev & pend_q);

  AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> pend_o); // R9
  AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (barrier_i && !set_i) |=> !pend_o); // R9
  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!barrier_i && !set_i) |=> (pend_o == $past(pend_o))); // R9
  AST_EXIT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dbg_i) && !dbg_i && pend_o) |-> unpred_o); // R11
endmodule

// File: rtl/psr_access_unit.sv
module psr_access_unit
  import psr_pkg::*;
#(
  parameter logic [31:0] RESET_CUR = 32'h0000_01D3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        dbg_i,
  input  logic        wr_en_i,
  input  logic        wr_saved_i,
  input  logic [3:0]  field_mask_i,
  input  logic [31:0] wr_data_i,
  input  logic        rd_en_i,
  input  logic        rd_saved_i,
  input  logic        barrier_i,
  output logic [31:0] rd_data_o,
  output logic        sync_pend_o,
  output logic        unknown_o,
  output logic        unpred_o
);
  logic [PSR_W-1:0] cur_q, sav_q;
  logic [PSR_W-1:0] cur_next, sav_next;
  logic             cur_wr, sav_wr;
  logic             cur_exec_chg, sav_exec_chg;
  logic             set_ev, partial_ev, rd_cur_ev;

  assign cur_wr = wr_en_i & ~wr_saved_i;
  assign sav_wr = wr_en_i &  wr_saved_i;

  psr_write_path #(.PROTECT(1'b1)) u_cur_wp (
    .old_i(cur_q), .data_i(wr_data_i), .lanes_i(field_mask_i), .en_i(cur_wr),
    .dbg_i(dbg_i), .next_o(cur_next), .exec_chg_o(cur_exec_chg));

  psr_write_path #(.PROTECT(1'b0)) u_sav_wp (
    .old_i(sav_q), .data_i(wr_data_i), .lanes_i(field_mask_i), .en_i(sav_wr),
    .dbg_i(dbg_i), .next_o(sav_next), .exec_chg_o(sav_exec_chg));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q <= RESET_CUR;
      sav_q <= '0;
    end else begin
      cur_q <= cur_next;
      sav_q <= sav_next;
    end
  end

  // Named events brought out for the tracker and the assertions
  assign set_ev     = dbg_i & cur_exec_chg;
  assign partial_ev = dbg_i & cur_wr & (field_mask_i != {LANES{1'b1}});
  assign rd_cur_ev  = rd_en_i & ~rd_saved_i;

  psr_sync_tracker u_sync (
    .clk(clk), .rst_n(rst_n), .dbg_i(dbg_i), .set_i(set_ev), .barrier_i(barrier_i),
    .partial_i(partial_ev), .rd_cur_i(rd_cur_ev), .pend_o(sync_pend_o),
    .unknown_o(unknown_o), .unpred_o(unpred_o));

  assign rd_data_o = rd_saved_i ? sav_q : cur_view(cur_q, dbg_i);

  AST_RAZ_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbg_i && !rd_saved_i) |-> ((rd_data_o & EXEC_NO_E) == '0)); // R2
  AST_EXEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbg_i && cur_wr) |=> ((cur_q & EXEC_NO_E) == $past(cur_q & EXEC_NO_E))); // R3
  AST_DBG_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_i && !rd_saved_i) |-> (rd_data_o == cur_q)); // R4
  AST_DBG_FULL_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_i && cur_wr && field_mask_i == 4'hF) |=> (cur_q == $past(wr_data_i))); // R5
  AST_SAVED_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (sav_wr && field_mask_i == 4'hF) |=> (sav_q == $past(wr_data_i))); // R6
  AST_NO_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (field_mask_i == 4'h0) |=> $stable(cur_q)); // R7
  AST_PARTIAL_DBG: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_i && cur_wr && field_mask_i != 4'hF) |-> unpred_o); // R8
  AST_UNKNOWN_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && !rd_saved_i && sync_pend_o) |-> unknown_o); // R10
endmodule

// File: tb/sim_psr_access_unit.sv
module sim_psr_access_unit;
  localparam int CLK_PERIOD = 10;
  localparam int SWEEP_STEPS = 4000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dbg_i = 1'b0, wr_en_i = 1'b0, wr_saved_i = 1'b0;
  logic [3:0]  field_mask_i = 4'h0;
  logic [31:0] wr_data_i = '0;
  logic        rd_en_i = 1'b0, rd_saved_i = 1'b0, barrier_i = 1'b0;
  logic [31:0] rd_data_o;
  logic        sync_pend_o, unknown_o, unpred_o;

  int checks = 0;
  int fails = 0;

  // Bench model state
  logic [31:0] m_cur, m_sav;
  logic        m_pend, m_dbg_prev;
  logic [31:0] nx; // execution-state bits without the endianness bit

  always #(CLK_PERIOD/2) clk = ~clk;

  psr_access_unit u0 (
    .clk(clk), .rst_n(rst_n), .dbg_i(dbg_i), .wr_en_i(wr_en_i), .wr_saved_i(wr_saved_i),
    .field_mask_i(field_mask_i), .wr_data_i(wr_data_i), .rd_en_i(rd_en_i),
    .rd_saved_i(rd_saved_i), .barrier_i(barrier_i), .rd_data_o(rd_data_o),
    .sync_pend_o(sync_pend_o), .unknown_o(unknown_o), .unpred_o(unpred_o));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mdl_write(input logic [31:0] old, input logic [31:0] d,
                                            input logic [3:0] m, input logic prot);
    logic [31:0] r;
    r = old;
    for (int b = 0; b < 32; b++)
      if (m[b/8] && !(prot && nx[b])) r[b] = d[b];
    return r;
  endfunction

  task automatic step(input logic dbg, input logic wr, input logic sv, input logic [3:0] m,
                      input logic [31:0] d, input logic rd, input logic rs, input logic bar,
                      input string tag);
    logic [31:0] exp_rd, nxt_cur, nxt_sav, exec_bits;
    logic        exp_unk, exp_unp, nxt_pend, chg;
    @(negedge clk);
    dbg_i = dbg; wr_en_i = wr; wr_saved_i = sv; field_mask_i = m; wr_data_i = d;
    rd_en_i = rd; rd_saved_i = rs; barrier_i = bar;
    #1;
    exp_rd  = rs ? m_sav : (dbg ? m_cur : (m_cur & ~nx));
    exp_unk = rd && !rs && m_pend;
    exp_unp = (dbg && wr && !sv && m != 4'hF) || (m_dbg_prev && !dbg && m_pend);
    check({tag, " rd_data"}, rd_data_o, exp_rd);
    check({tag, " unknown"}, {31'b0, unknown_o}, {31'b0, exp_unk});
    check({tag, " unpred"}, {31'b0, unpred_o}, {31'b0, exp_unp});
    check({tag, " sync_pend"}, {31'b0, sync_pend_o}, {31'b0, m_pend});
    exec_bits = nx | (32'h1 << 9);
    nxt_cur = (wr && !sv) ? mdl_write(m_cur, d, m, !dbg) : m_cur;
    nxt_sav = (wr && sv) ? mdl_write(m_sav, d, m, 1'b0) : m_sav;
    chg = dbg && (((nxt_cur ^ m_cur) & exec_bits) != 0);
    nxt_pend = chg ? 1'b1 : (bar ? 1'b0 : m_pend);
    @(posedge clk);
    m_cur = nxt_cur; m_sav = nxt_sav; m_pend = nxt_pend; m_dbg_prev = dbg;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic d_dbg;
    nx = (32'h3 << 25) | (32'h1 << 24) | (32'h3F << 10) | (32'h1 << 5);
    m_cur = 32'h0000_01D3; m_sav = '0; m_pend = 1'b0; m_dbg_prev = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R12: reset state of both words and the barrier tracker
    step(0, 0, 0, 4'h0, 0, 1, 0, 0, "R12 reset cur");
    step(0, 0, 0, 4'h0, 0, 1, 1, 0, "R12 reset saved");
    // R1, R3: non-debug all-ones write; flags and E taken, other exec bits held
    step(0, 1, 0, 4'hF, 32'hFFFF_FFFF, 0, 0, 0, "R1 nondebug write");
    step(0, 0, 0, 4'h0, 0, 1, 0, 0, "R2 nondebug read");
    step(1, 0, 0, 4'h0, 0, 1, 0, 0, "R3 exec held, debug read");
    // R5, R10, R9: debug write of exec bits, read before barrier, barrier
    step(1, 1, 0, 4'hF, 32'h0700_FE20, 0, 0, 0, "R5 debug write");
    step(1, 0, 0, 4'h0, 0, 1, 0, 0, "R10 read before barrier");
    step(1, 0, 0, 4'h0, 0, 0, 0, 1, "R9 barrier");
    step(1, 0, 0, 4'h0, 0, 1, 0, 0, "R4 debug read");
    step(0, 0, 0, 4'h0, 0, 1, 0, 0, "R2 E visible");
    // R7, R6: lane selection and unmasked saved word
    step(0, 1, 1, 4'b0101, 32'hAAAA_AAAA, 0, 1, 0, "R7 lane write");
    step(0, 0, 0, 4'h0, 0, 1, 1, 0, "R7 lane read");
    step(0, 1, 1, 4'hF, 32'h0700_FE20, 0, 1, 0, "R6 saved write");
    step(0, 0, 0, 4'h0, 0, 1, 1, 0, "R6 saved read");
    // R8, R11: partial debug write, then exit before barrier
    step(1, 1, 0, 4'b0011, 32'h0, 0, 0, 0, "R8 partial debug write");
    step(0, 0, 0, 4'h0, 0, 1, 0, 0, "R11 exit before barrier");
    step(0, 0, 0, 4'h0, 0, 0, 0, 1, "R9 barrier after exit");
    step(1, 1, 0, 4'hF, 32'h0500_0000, 0, 0, 1, "R9 set beats barrier");
    step(1, 0, 0, 4'h0, 0, 1, 0, 0, "R9 still pending");

    // Sweep: all requests, states and lane masks mixed
    d_dbg = 1'b1;
    for (int i = 0; i < SWEEP_STEPS; i++) begin
      logic [3:0] m;
      if (($urandom % 12) == 0) d_dbg = ~d_dbg;
      m = (($urandom % 2) == 0) ? 4'hF : 4'($urandom);
      step(d_dbg, ($urandom % 2) == 0, ($urandom % 3) == 0, m, $urandom,
           ($urandom % 2) == 0, ($urandom % 3) == 0, ($urandom % 6) == 0, "R1 sweep");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule